// File: doc/BRIEF.md
# Serial EEPROM Page-Write Buffer and Programming Sequencer

This block sits behind the serial-bus protocol engine of a small byte-addressed EEPROM. After a write command, the engine hands it a start address and then one strobe per received data byte. The block holds the bytes in an eight-entry page buffer, with one valid flag per entry. Between bytes, only the low three address bits advance, so every byte of one write lands in the same page. When the engine reports a STOP, the block starts a self-timed programming cycle, provided that at least one byte is held and write protection is off. The cycle has two phases. The erase phase drives all ones into each selected location. The write phase then drives the buffered values into the same locations.

During the cycle, `busy` is high so that the protocol engine withholds acknowledges. Strobes and address loads that arrive in this time are ignored. The high-voltage timing is modelled by two cycle-count parameters. When the cycle ends, the valid flags are cleared and the address counter points at the last byte that was entered.

Top module: `eeprom_page_prog`

## Requirements
- R1: Each accepted byte is stored at in-page offset `cur_addr[2:0]`. Only those three bits then increment, wrapping 7 to 0, and `cur_addr[7:3]` keeps its value.
- R2: Only the offsets that received a byte are written to the array. Other locations of the page and of the array are never written.
- R3: A STOP with no byte held since the last address load starts no cycle: `busy` stays low and `arr_we` stays low.
- R4: In a cycle, the erase phase writes 8'hFF once to each selected location, in ascending offset order. The write phase then writes each buffered byte once, in ascending offset order, and every erase write comes before every data write.
- R5: `busy` rises in the cycle after the STOP and stays high for exactly ERASE_CYCLES + WRITE_CYCLES cycles.
- R6: If `wp` is high at the STOP, the buffered bytes are discarded with no array write and `busy` stays low.
- R7: After a cycle, or after a discarded STOP, `cur_addr` equals the address of the last byte entered and no byte remains held.
- R8: While `busy` is high, `byte_stb` and `addr_load` have no effect. The buffer contents and `cur_addr` are unchanged.
- R9: An address load discards any bytes held from an earlier address load.
- R10: With more than eight bytes, the offset wraps and a later byte replaces the earlier byte at the same offset. Only the last value per offset is programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_load | input | 1 | Load `addr_in` as the start address and discard held bytes |
| addr_in | input | ADDR_W | Start address from the address byte |
| byte_stb | input | 1 | One pulse per acknowledged data byte |
| byte_data | input | DATA_W | Data byte for `byte_stb` |
| stop_evt | input | 1 | STOP condition seen on the bus |
| wp | input | 1 | Hardware write protect, high protects the whole array |
| busy | output | 1 | Programming cycle running; command bytes must not be acknowledged |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data (all ones in the erase phase) |
| cur_addr | output | ADDR_W | Internal address counter |

## Verification
A wrong offset or a lost valid flag shows at the ports during the next programming cycle. The array write stream then has the wrong addresses or the wrong count, or it lacks the all-ones erase before the data, and the bench compares that stream entry by entry against a list it computes from the bytes it sent. A counter fault shows in `cur_addr` as soon as the byte strobes end. A phase counter that is off by one changes the measured `busy` length at the end of the same cycle. Stale valid flags show one STOP later, when a STOP with no bytes starts a cycle it should not.

// File: rtl/eepg_pkg.sv
`timescale 1ns/1ps
package eepg_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ERASE = 2'd1,
      PH_WRITE = 2'd2
   } prog_ph_t;
endpackage

// File: rtl/eepg_addr_ctr.sv
`timescale 1ns/1ps
module eepg_addr_ctr #(
   parameter int ADDR_W = 8,
   parameter int OFF_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   input  logic              restore,
   output logic [ADDR_W-1:0] cur_addr
);
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] last_q;
   logic [OFF_W-1:0]  off_nxt;

   assign off_nxt  = cur_q[OFF_W-1:0] + 1'b1;
   assign cur_addr = cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         last_q <= '0;
      end else if (load) begin
         cur_q  <= load_addr;
         last_q <= load_addr;
      end else if (step) begin
         cur_q  <= {cur_q[ADDR_W-1:OFF_W], off_nxt};
         last_q <= cur_q;
      end else if (restore) begin
         cur_q  <= last_q;
      end
   end

   // R1: page bits never move on a data byte
   assert_page_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> cur_addr[ADDR_W-1:OFF_W] == $past(cur_addr[ADDR_W-1:OFF_W]));
endmodule

// File: rtl/eepg_page_buf.sv
`timescale 1ns/1ps
module eepg_page_buf #(
   parameter int PAGE_BYTES = 8,
   parameter int DATA_W     = 8,
   parameter int OFF_W      = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [OFF_W-1:0]      wr_off,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  clr,
   input  logic [OFF_W-1:0]      rd_off,
   output logic [PAGE_BYTES-1:0] valid,
   output logic [DATA_W-1:0]     rd_data
);
   logic [DATA_W-1:0] slot_data [PAGE_BYTES];

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      logic              v_q;
      logic [DATA_W-1:0] d_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
         end else if (clr) begin
            v_q <= 1'b0;
         end else if (wr_en && (wr_off == OFF_W'(g))) begin
            v_q <= 1'b1;
            d_q <= wr_data;
         end
      end
      assign valid[g]     = v_q;
      assign slot_data[g] = d_q;
   end

   assign rd_data = slot_data[rd_off];

   // R1/R10: the addressed slot holds a byte after a write
   assert_slot_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr) |=> valid[$past(wr_off)]);
endmodule

// File: rtl/eepg_prog_seq.sv
`timescale 1ns/1ps
module eepg_prog_seq
   import eepg_pkg::*;
#(
   parameter int PAGE_BYTES   = 8,
   parameter int ERASE_CYCLES = 10,
   parameter int WRITE_CYCLES = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          stop_evt,
   input  logic                          wp,
   input  logic                          any_valid,
   output logic                          busy,
   output logic                          erase_ph,
   output logic                          slot_act,
   output logic [$clog2(PAGE_BYTES)-1:0] slot_off,
   output logic                          finish
);
   localparam int OFF_W = $clog2(PAGE_BYTES);
   localparam int MAXC  = (ERASE_CYCLES > WRITE_CYCLES) ? ERASE_CYCLES : WRITE_CYCLES;
   localparam int TW    = $clog2(MAXC + 1);

   prog_ph_t      ph_q;
   logic [TW-1:0] tmr_q;
   logic          start_ok;
   logic          erase_end;
   logic          write_end;

   assign start_ok  = stop_evt && any_valid && !wp;
   assign erase_end = (ph_q == PH_ERASE) && (tmr_q == TW'(ERASE_CYCLES - 1));
   assign write_end = (ph_q == PH_WRITE) && (tmr_q == TW'(WRITE_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         tmr_q <= '0;
      end else begin
         case (ph_q)
            PH_IDLE: begin
               tmr_q <= '0;
               if (start_ok) ph_q <= PH_ERASE;
            end
            PH_ERASE: begin
               if (erase_end) begin
                  ph_q  <= PH_WRITE;
                  tmr_q <= '0;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            PH_WRITE: begin
               if (write_end) begin
                  ph_q  <= PH_IDLE;
                  tmr_q <= '0;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            default: begin
               ph_q  <= PH_IDLE;
               tmr_q <= '0;
            end
         endcase
      end
   end

   assign busy     = (ph_q != PH_IDLE);
   assign erase_ph = (ph_q == PH_ERASE);
   assign slot_act = busy && (tmr_q < TW'(PAGE_BYTES));
   assign slot_off = tmr_q[OFF_W-1:0];
   assign finish   = write_end || ((ph_q == PH_IDLE) && stop_evt && !start_ok);

   // R3/R6: a cycle starts only from a STOP with held bytes and no protection
   assert_start_needs_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(stop_evt) && $past(any_valid) && !$past(wp)));
   // R4: erase phase is always followed by the write phase
   assert_erase_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      erase_end |=> (busy && !erase_ph));
endmodule

// File: rtl/eeprom_page_prog.sv
`timescale 1ns/1ps
module eeprom_page_prog #(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 8,
   parameter int PAGE_BYTES   = 8,
   parameter int ERASE_CYCLES = 10,
   parameter int WRITE_CYCLES = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              byte_stb,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              stop_evt,
   input  logic              wp,
   output logic              busy,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_wdata,
   output logic [ADDR_W-1:0] cur_addr
);
   localparam int OFF_W = $clog2(PAGE_BYTES);

   if (PAGE_BYTES < 2 || (1 << OFF_W) != PAGE_BYTES) begin : g_chk_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W <= OFF_W) begin : g_chk_addr
      $error("ADDR_W must exceed the in-page offset width");
   end
   if (ERASE_CYCLES < PAGE_BYTES || WRITE_CYCLES < PAGE_BYTES) begin : g_chk_cyc
      $error("each phase needs at least PAGE_BYTES cycles");
   end

   logic                  acc_byte;
   logic                  acc_load;
   logic [PAGE_BYTES-1:0] valid_mask;
   logic [DATA_W-1:0]     buf_data;
   logic                  erase_ph;
   logic                  slot_act;
   logic [OFF_W-1:0]      slot_off;
   logic                  finish;

   assign acc_byte = byte_stb && !busy && !addr_load;
   assign acc_load = addr_load && !busy;

   eepg_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (acc_load),
      .load_addr (addr_in),
      .step      (acc_byte),
      .restore   (finish),
      .cur_addr  (cur_addr)
   );

   eepg_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (acc_byte),
      .wr_off  (cur_addr[OFF_W-1:0]),
      .wr_data (byte_data),
      .clr     (finish || acc_load),
      .rd_off  (slot_off),
      .valid   (valid_mask),
      .rd_data (buf_data)
   );

   eepg_prog_seq #(
      .PAGE_BYTES   (PAGE_BYTES),
      .ERASE_CYCLES (ERASE_CYCLES),
      .WRITE_CYCLES (WRITE_CYCLES)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .stop_evt  (stop_evt),
      .wp        (wp),
      .any_valid (|valid_mask),
      .busy      (busy),
      .erase_ph  (erase_ph),
      .slot_act  (slot_act),
      .slot_off  (slot_off),
      .finish    (finish)
   );

   assign arr_we    = slot_act && valid_mask[slot_off];
   assign arr_addr  = {cur_addr[ADDR_W-1:OFF_W], slot_off};
   assign arr_wdata = erase_ph ? {DATA_W{1'b1}} : buf_data;

   // R8: buffer and counter frozen while programming
   assert_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($stable(cur_addr) && $stable(valid_mask)));
   // R6: protected STOP never raises busy
   assert_wp_no_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && wp && !busy) |=> !busy);
   // R7: nothing held once the cycle ends
   assert_clear_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (valid_mask == '0));
endmodule

// File: tb/eeprom_page_prog_tb.sv
`timescale 1ns/1ps
module eeprom_page_prog_tb;
   localparam int EC = 10;
   localparam int WC = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_load = 1'b0;
   logic [7:0] addr_in = '0;
   logic       byte_stb = 1'b0;
   logic [7:0] byte_data = '0;
   logic       stop_evt = 1'b0;
   logic       wp = 1'b0;
   logic       busy, arr_we;
   logic [7:0] arr_addr, arr_wdata, cur_addr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [7:0] bmem [256];
   logic [7:0] emem [256];

   always #5 clk = ~clk;

   eeprom_page_prog #(.ERASE_CYCLES(EC), .WRITE_CYCLES(WC)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
      .byte_stb(byte_stb), .byte_data(byte_data), .stop_evt(stop_evt), .wp(wp),
      .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
      .cur_addr(cur_addr)
   );

   function automatic logic [7:0] in_page(logic [7:0] base, int k);
      return {base[7:3], 3'((int'(base[2:0]) + k) % 8)};
   endfunction

   task automatic chk(bit ok, string tag, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic run_txn(logic [7:0] start, int n, bit wpv, bit poke, bit pre);
      logic [7:0] dat [16];
      bit         ev [8];
      logic [7:0] edat [8];
      logic [7:0] wa [32], wd [32], xa [32], xd [32];
      int nw = 0, nx = 0, nb = 0;
      logic [7:0] last;
      for (int i = 0; i < 16; i++) dat[i] = 8'($urandom);
      for (int i = 0; i < 8; i++) ev[i] = 1'b0;
      if (pre) begin
         addr_load = 1'b1; addr_in = ~start;
         @(negedge clk); addr_load = 1'b0;
         for (int i = 0; i < 2; i++) begin
            byte_stb = 1'b1; byte_data = 8'($urandom);
            @(negedge clk);
         end
         byte_stb = 1'b0;
      end
      addr_load = 1'b1; addr_in = start;
      @(negedge clk); addr_load = 1'b0;
      for (int i = 0; i < n; i++) begin
         byte_stb = 1'b1; byte_data = dat[i];
         @(negedge clk);
         ev[(int'(start[2:0]) + i) % 8] = 1'b1;
         edat[(int'(start[2:0]) + i) % 8] = dat[i];
      end
      byte_stb = 1'b0;
      last = in_page(start, n - 1);
      chk(cur_addr == in_page(start, n), "R1 counter after bytes", cur_addr, in_page(start, n));
      wp = wpv; stop_evt = 1'b1;
      @(negedge clk); stop_evt = 1'b0;
      while (busy && nb < 1000) begin
         if (poke && nb == 3) begin
            byte_stb = 1'b1; addr_load = 1'b1; addr_in = 8'($urandom); byte_data = 8'($urandom);
         end else begin
            byte_stb = 1'b0; addr_load = 1'b0;
         end
         if (arr_we && nw < 32) begin
            wa[nw] = arr_addr; wd[nw] = arr_wdata; nw++;
            bmem[arr_addr] = arr_wdata;
         end
         nb++;
         @(negedge clk);
      end
      byte_stb = 1'b0; addr_load = 1'b0; wp = 1'b0;
      if (!wpv) begin
         for (int o = 0; o < 8; o++)
            if (ev[o]) begin xa[nx] = {start[7:3], 3'(o)}; xd[nx] = 8'hFF; nx++; end
         for (int o = 0; o < 8; o++)
            if (ev[o]) begin
               xa[nx] = {start[7:3], 3'(o)}; xd[nx] = edat[o]; nx++;
               emem[{start[7:3], 3'(o)}] = edat[o];
            end
      end
      if (wpv) chk(nb == 0, "R6 busy under protect", nb, 0);
      else     chk(nb == EC + WC, "R5 busy length", nb, EC + WC);
      chk(nw == nx, wpv ? "R6 write count" : "R4 write count", nw, nx);
      for (int k = 0; k < nw && k < nx; k++) begin
         chk(wa[k] == xa[k], "R2 write address", wa[k], xa[k]);
         chk(wd[k] == xd[k], "R4 write data/order", wd[k], xd[k]);
      end
      chk(cur_addr == last, "R7 counter at last byte", cur_addr, last);
      for (int o = 0; o < 8; o++) begin
         logic [7:0] a;
         a = {start[7:3], 3'(o)};
         chk(bmem[a] == emem[a], pre ? "R9 page contents" : (n > 8 ? "R10 page contents" : "R2 page contents"),
             bmem[a], emem[a]);
      end
      if (poke) begin
         stop_evt = 1'b1;
         @(negedge clk); stop_evt = 1'b0;
         chk(busy == 1'b0, "R8 strobe during busy ignored", busy, 0);
         chk(cur_addr == last, "R8 counter untouched", cur_addr, last);
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240));
      for (int i = 0; i < 256; i++) begin bmem[i] = '0; emem[i] = '0; end
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && arr_we == 1'b0, "R5 reset idle", busy, 0);
      chk(cur_addr == 8'h00, "R1 reset counter", cur_addr, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R3: address load then STOP with no bytes
      addr_load = 1'b1; addr_in = 8'h40;
      @(negedge clk); addr_load = 1'b0; stop_evt = 1'b1;
      @(negedge clk); stop_evt = 1'b0;
      chk(busy == 1'b0 && arr_we == 1'b0, "R3 empty STOP", busy, 0);
      run_txn(8'h20, 8, 1'b0, 1'b0, 1'b0);   // full page
      run_txn(8'h56, 3, 1'b0, 1'b0, 1'b0);   // in-page wrap (R1)
      run_txn(8'h93, 11, 1'b0, 1'b0, 1'b0);  // overwrite (R10)
      run_txn(8'h93, 4, 1'b1, 1'b0, 1'b0);   // protected (R6)
      run_txn(8'hC8, 1, 1'b0, 1'b1, 1'b0);   // single byte, pokes (R8)
      run_txn(8'h0F, 2, 1'b0, 1'b0, 1'b1);   // reload discards (R9)
      for (int t = 0; t < 40; t++)
         run_txn(8'($urandom), 1 + int'($urandom % 10), ($urandom % 5) == 0,
                 ($urandom % 3) == 0, ($urandom % 4) == 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule